// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block takes a single missed word address from a cache miss handler and turns it into one wrapping read burst that covers the whole aligned cache line. The burst starts at the word that missed. The returning data beats therefore arrive rotated. Each beat is steered into its own slot of a line buffer according to its position in the wrap, not according to how many beats have arrived.

The word that missed is handed to the processor one cycle after the first beat is accepted, so the processor does not wait for the rest of the line. A one-cycle completion pulse follows the beat that carries the read-last flag. A lookup port reports whether any word of the line being filled, or last filled, is already present in the buffer. This lets a later hit to that line be served from a slot that has already been written.

A sticky error flag records a read-last flag that does not fall on the final beat of the line.

Top module: `cwf_fill_buf`

## Requirements
- R1: After reset, miss_ready is 1 and ar_valid, r_ready, cpu_word_valid, fill_done, proto_err and hit_valid are all 0.
- R2: In the cycle after a miss is accepted (miss_valid and miss_ready high at a clock edge), ar_valid rises. The request then shows:
  - ar_addr equal to miss_addr with its two lowest bits cleared;
  - ar_burst = 2'b10 (wrapping);
  - ar_len = 3 and ar_size = 2 (4 words of 32 bits).

  The request fields hold stable until ar_ready is seen high at an edge.
- R3: miss_ready is low from the cycle after a miss is accepted until the fill ends. A miss_valid seen while miss_ready is low is ignored: it changes no request and no buffer state.
- R4: cpu_word_valid is a one-cycle pulse in the cycle after the first data beat is accepted. It occurs exactly once per fill, and cpu_word then carries that beat's data.
- R5: Data beat k of a fill is written to slot (s + k) mod 4. Here s is miss_addr bits [3:2], and slot n holds the word at line base + 4·n. Every slot is written exactly once by a 4-beat fill.
- R6: fill_done is a one-cycle pulse in the cycle after the beat that ends the fill. In that same cycle miss_ready is high again.
- R7: A fill ends on the first beat that carries r_last or that is the fourth beat. proto_err rises in the next cycle if r_last appears on a beat other than the fourth, or if it is absent on the fourth beat. proto_err then stays high until reset.
- R8: hit_valid is high when all three of these hold:
  - a miss has been accepted since reset;
  - hit_addr bits [31:4] equal those of the last accepted miss;
  - the slot selected by hit_addr bits [3:2] has been written since that miss was accepted.

  When hit_valid is high, hit_data is the word in that slot; otherwise hit_data is 0.
- R9: r_ready is high only while the data beats of an issued request are expected. A beat offered at any other time writes nothing and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address of the missed word |
| miss_ready | output | 1 | Block idle, miss can be accepted |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| ar_addr | output | 32 | Burst start address (missed word) |
| ar_len | output | 8 | Beats minus one |
| ar_size | output | 3 | log2 of bytes per beat |
| ar_burst | output | 2 | Burst type, wrapping |
| r_valid | input | 1 | Read data beat present |
| r_ready | output | 1 | Beat accepted when high |
| r_data | input | 32 | Read data |
| r_last | input | 1 | Final beat marker |
| cpu_word_valid | output | 1 | Critical word pulse |
| cpu_word | output | 32 | Critical word data |
| fill_done | output | 1 | Line complete pulse |
| proto_err | output | 1 | Sticky beat-count error |
| hit_addr | input | 32 | Lookup byte address |
| hit_valid | output | 1 | Looked-up word present |
| hit_data | output | 32 | Looked-up word |

## Verification
The bench goes after the following corner cases:

- **Start slot 3.** The second beat must wrap straight to the line base. A design that steers by arrival count would put every word one or more slots off, and the lookup port would return the wrong data.
- **Start slot 0.** Here the rotation is empty. A design with an off-by-one in the wrap arithmetic would shift every beat.
- **Early read-last.** Read-last arrives on the second beat. A design that counts beats without checking the flag would keep waiting and miss both the error and the completion pulse.
- **Stray inputs.** Misses are offered during a fill, and data beats are offered while the request is still pending. A design that accepts either would corrupt the request, or write slots before the burst has started.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_DATA = 2'd2
   } fill_state_e;

   localparam logic [1:0] BURST_WRAP = 2'b10;
endpackage

// File: rtl/cwf_req_gen.sv
module cwf_req_gen #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int BEAT_BYTES = DATA_W / 8,
   localparam int OFF_W      = $clog2(BEAT_BYTES),
   localparam int SLOT_W     = $clog2(LINE_WORDS),
   localparam int LINE_OFF_W = OFF_W + SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic [ADDR_W-1:0] req_addr,
   output logic [ADDR_W-LINE_OFF_W-1:0] line_tag,
   output logic [SLOT_W-1:0] start_slot,
   output logic [7:0]        len_code,
   output logic [2:0]        size_code
);
   generate
      if (LINE_WORDS != 2 && LINE_WORDS != 4 && LINE_WORDS != 8 && LINE_WORDS != 16) begin : g_bad_len
         $error("LINE_WORDS must be 2, 4, 8 or 16");
      end
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_w
         $error("DATA_W must be a power of two of at least 8");
      end
      if (ADDR_W <= LINE_OFF_W) begin : g_bad_a
         $error("ADDR_W too small for the line size");
      end
   endgenerate

   logic [ADDR_W-OFF_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load) begin
         word_q <= miss_addr[ADDR_W-1:OFF_W];
      end
   end

   generate
      if (OFF_W > 0) begin : g_off
         assign req_addr = {word_q, {OFF_W{1'b0}}};
      end else begin : g_nooff
         assign req_addr = word_q;
      end
   endgenerate

   assign line_tag   = word_q[ADDR_W-OFF_W-1:SLOT_W];
   assign start_slot = word_q[SLOT_W-1:0];
   assign len_code   = 8'(LINE_WORDS - 1);
   assign size_code  = 3'(OFF_W);
endmodule

// File: rtl/cwf_slot_steer.sv
module cwf_slot_steer #(
   parameter int LINE_WORDS = 4,
   localparam int SLOT_W    = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              beat,
   input  logic              last_in,
   input  logic [SLOT_W-1:0] start_slot,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [LINE_WORDS-1:0] slot_onehot,
   output logic              first_beat,
   output logic              fill_end,
   output logic              len_err
);
   logic [SLOT_W-1:0] cnt_q;
   logic              final_beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (beat) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign slot_idx   = start_slot + cnt_q;
   assign first_beat = (cnt_q == '0);
   assign final_beat = (cnt_q == SLOT_W'(LINE_WORDS - 1));
   assign fill_end   = beat && (last_in || final_beat);
   assign len_err    = beat && (last_in != final_beat);

   generate
      for (genvar i = 0; i < LINE_WORDS; i++) begin : g_dec
         assign slot_onehot[i] = beat && (slot_idx == SLOT_W'(i));
      end
   endgenerate
endmodule

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int SLOT_W    = $clog2(LINE_WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic [LINE_WORDS-1:0] wr_onehot,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [SLOT_W-1:0]     rd_slot,
   output logic                  rd_vld,
   output logic [DATA_W-1:0]     rd_data
);
   logic [DATA_W-1:0]     word_q [LINE_WORDS];
   logic [LINE_WORDS-1:0] vld_q;

   generate
      for (genvar i = 0; i < LINE_WORDS; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q[i] <= '0;
               vld_q[i]  <= 1'b0;
            end else if (clr) begin
               vld_q[i]  <= 1'b0;
            end else if (wr_onehot[i]) begin
               word_q[i] <= wr_data;
               vld_q[i]  <= 1'b1;
            end
         end
      end
   endgenerate

   assign rd_vld  = vld_q[rd_slot];
   assign rd_data = word_q[rd_slot];

   // R5
   wr_one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_onehot));

   // R5
   no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && |(wr_onehot & vld_q)) |-> 1'b0);
endmodule

// File: rtl/cwf_fill_buf.sv
module cwf_fill_buf #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int BEAT_BYTES = DATA_W / 8,
   localparam int OFF_W      = $clog2(BEAT_BYTES),
   localparam int SLOT_W     = $clog2(LINE_WORDS),
   localparam int LINE_OFF_W = OFF_W + SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [ADDR_W-1:0] miss_addr,
   output logic              miss_ready,
   output logic              ar_valid,
   input  logic              ar_ready,
   output logic [ADDR_W-1:0] ar_addr,
   output logic [7:0]        ar_len,
   output logic [2:0]        ar_size,
   output logic [1:0]        ar_burst,
   input  logic              r_valid,
   output logic              r_ready,
   input  logic [DATA_W-1:0] r_data,
   input  logic              r_last,
   output logic              cpu_word_valid,
   output logic [DATA_W-1:0] cpu_word,
   output logic              fill_done,
   output logic              proto_err,
   input  logic [ADDR_W-1:0] hit_addr,
   output logic              hit_valid,
   output logic [DATA_W-1:0] hit_data
);
   import cwf_pkg::*;

   fill_state_e state_q;
   logic        accept, ar_hs, beat;
   logic [ADDR_W-LINE_OFF_W-1:0] line_tag;
   logic [SLOT_W-1:0]     start_slot, slot_idx;
   logic [LINE_WORDS-1:0] slot_onehot;
   logic        first_beat, fill_end, len_err;
   logic        tag_known_q;
   logic        rd_vld;
   logic [DATA_W-1:0] rd_data;

   assign miss_ready = (state_q == FS_IDLE);
   assign ar_valid   = (state_q == FS_REQ);
   assign r_ready    = (state_q == FS_DATA);
   assign accept     = miss_valid && miss_ready;
   assign ar_hs      = ar_valid && ar_ready;
   assign beat       = r_valid && r_ready;
   assign ar_burst   = BURST_WRAP;

   cwf_req_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_req (
      .clk(clk), .rst_n(rst_n), .load(accept), .miss_addr(miss_addr),
      .req_addr(ar_addr), .line_tag(line_tag), .start_slot(start_slot),
      .len_code(ar_len), .size_code(ar_size)
   );

   cwf_slot_steer #(.LINE_WORDS(LINE_WORDS)) u_steer (
      .clk(clk), .rst_n(rst_n), .restart(ar_hs), .beat(beat), .last_in(r_last),
      .start_slot(start_slot), .slot_idx(slot_idx), .slot_onehot(slot_onehot),
      .first_beat(first_beat), .fill_end(fill_end), .len_err(len_err)
   );

   cwf_line_store #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(accept), .wr_onehot(slot_onehot),
      .wr_data(r_data), .rd_slot(hit_addr[LINE_OFF_W-1:OFF_W]),
      .rd_vld(rd_vld), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
      end else begin
         unique case (state_q)
            FS_IDLE: if (accept)   state_q <= FS_REQ;
            FS_REQ:  if (ar_hs)    state_q <= FS_DATA;
            FS_DATA: if (fill_end) state_q <= FS_IDLE;
            default:               state_q <= FS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_word_valid <= 1'b0;
         cpu_word       <= '0;
         fill_done      <= 1'b0;
         proto_err      <= 1'b0;
         tag_known_q    <= 1'b0;
      end else begin
         cpu_word_valid <= beat && first_beat;
         if (beat && first_beat) cpu_word <= r_data;
         fill_done <= fill_end;
         if (len_err) proto_err <= 1'b1;
         if (accept) tag_known_q <= 1'b1;
      end
   end

   assign hit_valid = tag_known_q && rd_vld &&
                      (hit_addr[ADDR_W-1:LINE_OFF_W] == line_tag);
   assign hit_data  = hit_valid ? rd_data : '0;

   // R2
   ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));

   // R4
   cpu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_word_valid |=> !cpu_word_valid);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (miss_ready && !$past(fill_done)));

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   // R9
   no_beat_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !r_ready |-> (slot_onehot == '0));
endmodule

// File: tb/tb_cwf_fill_buf.sv
module tb_cwf_fill_buf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_addr = '0;
   logic        miss_ready, ar_valid, r_ready;
   logic        ar_ready = 1'b0;
   logic [31:0] ar_addr;
   logic [7:0]  ar_len;
   logic [2:0]  ar_size;
   logic [1:0]  ar_burst;
   logic        r_valid = 1'b0;
   logic [31:0] r_data = '0;
   logic        r_last = 1'b0;
   logic        cpu_word_valid, fill_done, proto_err, hit_valid;
   logic [31:0] cpu_word, hit_data;
   logic [31:0] hit_addr = '0;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   cwf_fill_buf dut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .miss_ready(miss_ready), .ar_valid(ar_valid), .ar_ready(ar_ready),
      .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
      .cpu_word_valid(cpu_word_valid), .cpu_word(cpu_word), .fill_done(fill_done),
      .proto_err(proto_err), .hit_addr(hit_addr), .hit_valid(hit_valid),
      .hit_data(hit_data)
   );

   // reference model state
   int          m_phase;
   logic [31:0] m_req, m_tag;
   int          m_start, m_cnt;
   logic [31:0] m_line [4];
   bit          m_vld [4];
   bit          m_known, m_cwv, m_done, m_err;
   logic [31:0] m_cw;

   task automatic check(input bit ok, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", what, act, exp, cycles);
      end
   endtask

   task automatic model_update;
      m_cwv  = 0;
      m_done = 0;
      if (!rst_n) begin
         m_phase = 0; m_req = 0; m_tag = 0; m_start = 0; m_cnt = 0;
         m_known = 0; m_err = 0; m_cw = 0;
         for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_line[i] = 0; end
      end else begin
         case (m_phase)
            0: if (miss_valid) begin
                  m_req   = miss_addr & ~32'h3;
                  m_tag   = miss_addr >> 4;
                  m_start = int'((miss_addr >> 2) & 32'h3);
                  m_known = 1;
                  for (int i = 0; i < 4; i++) m_vld[i] = 0;
                  m_phase = 1;
               end
            1: if (ar_ready) begin m_phase = 2; m_cnt = 0; end
            default: if (r_valid) begin
                  int slot;
                  slot = (m_start + m_cnt) % 4;
                  m_line[slot] = r_data;
                  m_vld[slot]  = 1;
                  if (m_cnt == 0) begin m_cwv = 1; m_cw = r_data; end
                  if (r_last != (m_cnt == 3)) m_err = 1;
                  if (r_last || m_cnt == 3) begin m_phase = 0; m_done = 1; end
                  m_cnt++;
               end
         endcase
      end
   endtask

   task automatic compare_all;
      bit hv;
      int hs;
      hs = int'((hit_addr >> 2) & 32'h3);
      hv = m_known && ((hit_addr >> 4) == m_tag) && m_vld[hs];
      check(miss_ready == (m_phase == 0), "R3 miss_ready", 32'(miss_ready), 32'(m_phase == 0));
      check(ar_valid == (m_phase == 1), "R2 ar_valid", 32'(ar_valid), 32'(m_phase == 1));
      if (m_phase == 1) begin
         check(ar_addr == m_req, "R2 ar_addr", ar_addr, m_req);
         check(ar_len == 8'd3, "R2 ar_len", 32'(ar_len), 32'd3);
         check(ar_size == 3'd2, "R2 ar_size", 32'(ar_size), 32'd2);
         check(ar_burst == 2'b10, "R2 ar_burst", 32'(ar_burst), 32'd2);
      end
      check(r_ready == (m_phase == 2), "R9 r_ready", 32'(r_ready), 32'(m_phase == 2));
      check(cpu_word_valid == m_cwv, "R4 cpu_word_valid", 32'(cpu_word_valid), 32'(m_cwv));
      if (m_cwv) check(cpu_word == m_cw, "R4 cpu_word", cpu_word, m_cw);
      check(fill_done == m_done, "R6 fill_done", 32'(fill_done), 32'(m_done));
      check(proto_err == m_err, "R7 proto_err", 32'(proto_err), 32'(m_err));
      check(hit_valid == hv, "R8 hit_valid", 32'(hit_valid), 32'(hv));
      check(hit_data == (hv ? m_line[hs] : 32'h0), "R5 hit_data", hit_data,
            hv ? m_line[hs] : 32'h0);
   endtask

   task automatic step;
      @(posedge clk);
      cycles++;
      model_update();
      @(negedge clk);
      compare_all();
   endtask

   // last_at: beat index carrying r_last; noise: offer a beat during the request phase
   task automatic fill(input logic [31:0] addr, input logic [31:0] dbase,
                       input int last_at, input bit noise);
      miss_valid = 1; miss_addr = addr;
      step();
      miss_addr = 32'hDEAD_0000;       // R3: stray miss during the fill
      ar_ready = 0;
      if (noise) begin r_valid = 1; r_data = 32'hBAD0_BAD0; r_last = 1; end  // R9
      step(); step();
      ar_ready = 1;
      step();
      ar_ready = 0; r_valid = 0; r_last = 0;
      for (int k = 0; k < 4; k++) begin
         r_valid = 1; r_data = dbase + 32'(k); r_last = (k == last_at);
         step();
         if (k == 0) miss_valid = 0;
         r_valid = 0; r_last = 0;
         hit_addr = (addr & ~32'hF) | 32'(k * 4);
         step();
         if (k == last_at) break;
      end
   endtask

   initial begin
      int guard;
      guard = 0;
      while (!finished && guard < 100000) begin
         @(posedge clk);
         guard++;
      end
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", guard, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      step(); step();
      // R1: reset state
      check(miss_ready && !ar_valid && !r_ready && !cpu_word_valid && !fill_done &&
            !proto_err && !hit_valid, "R1 reset outputs",
            {25'b0, miss_ready, ar_valid, r_ready, cpu_word_valid, fill_done, proto_err, hit_valid},
            32'h40);
      @(negedge clk); rst_n = 1;
      step();

      // start slot 2: beats land in 2,3,0,1
      fill(32'h0000_1008, 32'hA000_0000, 3, 0);
      for (int s = 0; s < 4; s++) begin
         hit_addr = 32'h0000_1000 + 32'(s * 4);
         step();
      end
      hit_addr = 32'h0000_1000; step();
      check(hit_valid && hit_data == 32'hA000_0002, "R5 slot0 from beat2", hit_data, 32'hA000_0002);
      hit_addr = 32'h0000_100C; step();
      check(hit_valid && hit_data == 32'hA000_0001, "R5 slot3 from beat1", hit_data, 32'hA000_0001);
      hit_addr = 32'h0000_2008; step();
      check(!hit_valid && hit_data == 0, "R8 other line misses", 32'(hit_valid), 32'h0);

      // start slot 3 with a stray beat during the request phase
      fill(32'h0000_200C, 32'hB000_0000, 3, 1);
      hit_addr = 32'h0000_2000; step();
      check(hit_valid && hit_data == 32'hB000_0001, "R5 wrap to base", hit_data, 32'hB000_0001);

      // start slot 0, low address bits set
      fill(32'h0000_3002, 32'hC000_0000, 3, 0);
      hit_addr = 32'h0000_3008; step();
      check(hit_data == 32'hC000_0002, "R5 no rotation", hit_data, 32'hC000_0002);

      // early read-last on beat 1
      fill(32'h0000_4004, 32'hD000_0000, 1, 0);
      hit_addr = 32'h0000_400C; step();
      check(!hit_valid, "R7 unfilled slot after early end", 32'(hit_valid), 32'h0);
      check(proto_err, "R7 error raised", 32'(proto_err), 32'h1);

      // later good fill, error stays
      fill(32'h0000_5008, 32'hE000_0000, 3, 0);
      for (int s = 0; s < 4; s++) begin
         hit_addr = 32'h0000_5000 + 32'(s * 4);
         step();
      end
      check(proto_err, "R7 error sticky", 32'(proto_err), 32'h1);

      // missing read-last on the fourth beat
      @(negedge clk); rst_n = 0; step(); @(negedge clk); rst_n = 1; step();
      fill(32'h0000_6004, 32'hF000_0000, 9, 0);
      step();
      check(proto_err && miss_ready, "R7 no last on fourth beat", 32'(proto_err), 32'h1);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule